// File: doc/BRIEF.md
# Locality Ownership Register Controller

This block is the ownership front end of a memory-mapped command interface for a security module. Software reaches it through byte-addressable reads and writes of one, two or four bytes. The address bits above bit 11 select a locality window, and the low twelve bits select a register inside that window. A write of a single command code to the control register either claims the interface or gives it up. Two registers record the outcome: a state register and a status register. Both are updated together by the same write.

The block exports the owning locality to neighbouring logic every cycle. When nobody holds the interface it exports the code 0xFF. An external input carries the module's establishment flag, and a read of the state register merges the inverse of that flag into bit 0. Only locality 0 is offered. Forced takeover and clearing of the establishment flag are accepted as commands but have no effect.

Top module: `lo_ownership_ctrl`

## Requirements
- R1: After synchronous reset the state word is 0x80 with bit 0 equal to the inverse of `est_flag`, the status word is 0, and `active_loc` is 0xFF. Within a window, the state register is at byte offset 0x000, the control register at 0x008 and the status register at 0x00C.
- R2: A value of exactly 0x1 written to the control register takes ownership. It sets the assigned bit (state bit 1) and the granted bit (status bit 0), clears the seized bit (status bit 1), and records the writer's locality in state bits 4:2.
- R3: A value of exactly 0x2 written to the control register releases ownership. It clears the assigned bit and the granted bit.
- R4: Any other value written to the control register changes nothing. This includes 0x4 (seize), 0x8 (establishment reset), 0x0 and values with more than one bit set.
- R5: A write is applied only when `acc_size` is 2 (four bytes) and `addr[1:0]` is 0. Narrower or misaligned writes are dropped.
- R6: The locality of an access is `addr >> 12`. Control writes from a locality of `NUM_LOC` or above are dropped.
- R7: A read of the state register returns bit 0 as the inverse of `est_flag`, sampled in the read cycle.
- R8: A read returns the 32-bit word that contains the address, shifted right by 8 times `addr[1:0]`, on `rd_data`, with `rd_valid` high one cycle after `rd_en`. The control register and unmapped offsets read as 0.
- R9: `active_loc` is registered. It shows the recorded owner while the assigned bit is set and 0xFF otherwise, and it changes on the same clock edge that applies the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address; upper bits give the locality |
| acc_size | input | 2 | Access width: 0 one byte, 1 two bytes, 2 four bytes |
| wr_data | input | 32 | Write data |
| est_flag | input | 1 | External establishment flag |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| active_loc | output | 8 | Owning locality, or 0xFF when none |

## Verification
A lost or stuck assigned bit shows up on `active_loc` on the edge right after the command write. It shows up in state and status reads one cycle after the read strobe. A control write decoded under the wrong condition shows as a stale or changed owner after a dropped write, because the bench reads both registers back after every write. A shift or merge error in the read path shows at the byte offsets of the state word, since the exact read value is compared on every read.

// File: rtl/lo_pkg.sv
package lo_pkg;
  localparam int unsigned OFF_W = 12;

  localparam logic [OFF_W-1:0] OFF_STATE = 12'h000;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 12'h008;
  localparam logic [OFF_W-1:0] OFF_STS   = 12'h00C;

  localparam logic [31:0] CMD_CLAIM   = 32'h0000_0001;
  localparam logic [31:0] CMD_RELEASE = 32'h0000_0002;

  localparam logic [7:0] LOC_NONE = 8'hFF;
  localparam logic [1:0] SZ_WORD  = 2'd2;

  localparam int unsigned ST_EST_BIT   = 0;
  localparam int unsigned ST_ASGN_BIT  = 1;
  localparam int unsigned ST_OWN_LSB   = 2;
  localparam int unsigned ST_OWN_W     = 3;
  localparam int unsigned ST_VALID_BIT = 7;
  localparam int unsigned SS_GRANT_BIT = 0;
  localparam int unsigned SS_SEIZE_BIT = 1;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_STATE = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_STS   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/lo_addr_dec.sv
module lo_addr_dec
  import lo_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned NUM_LOC = 1,
  localparam int unsigned LOC_W  = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        acc_size,
  output reg_sel_e          sel,
  output logic [LOC_W-1:0]  loc,
  output logic [1:0]        byte_off,
  output logic              ctrl_wr
);
  logic [OFF_W-1:0] word_off;
  logic             full_word;
  logic             loc_ok;

  always_comb begin
    loc       = addr[ADDR_W-1:OFF_W];
    byte_off  = addr[1:0];
    word_off  = {addr[OFF_W-1:2], 2'b00};
    full_word = (acc_size == SZ_WORD) && (addr[1:0] == 2'b00);
    loc_ok    = ({{(32-LOC_W){1'b0}}, loc} < NUM_LOC[31:0]);
    unique case (word_off)
      OFF_STATE: sel = SEL_STATE;
      OFF_CTRL:  sel = SEL_CTRL;
      OFF_STS:   sel = SEL_STS;
      default:   sel = SEL_NONE;
    endcase
    ctrl_wr = wr_en && full_word && loc_ok && (sel == SEL_CTRL);
  end
endmodule

// File: rtl/lo_own_regs.sv
module lo_own_regs
  import lo_pkg::*;
#(
  parameter int unsigned LOC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [31:0]      wr_data,
  input  logic [LOC_W-1:0] wr_loc,
  output logic             assigned,
  output logic             granted,
  output logic             seized,
  output logic [LOC_W-1:0] owner,
  output logic [7:0]       active_loc
);
  logic             asgn_q, grant_q, seize_q;
  logic [LOC_W-1:0] owner_q;
  logic [7:0]       act_q;
  logic             asgn_d, grant_d, seize_d;
  logic [LOC_W-1:0] owner_d;

  always_comb begin
    asgn_d  = asgn_q;
    grant_d = grant_q;
    seize_d = seize_q;
    owner_d = owner_q;
    if (ctrl_wr) begin
      if (wr_data == CMD_CLAIM) begin
        asgn_d  = 1'b1;
        grant_d = 1'b1;
        seize_d = 1'b0;
        owner_d = wr_loc;
      end else if (wr_data == CMD_RELEASE) begin
        asgn_d  = 1'b0;
        grant_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asgn_q  <= 1'b0;
      grant_q <= 1'b0;
      seize_q <= 1'b0;
      owner_q <= '0;
      act_q   <= LOC_NONE;
    end else begin
      asgn_q  <= asgn_d;
      grant_q <= grant_d;
      seize_q <= seize_d;
      owner_q <= owner_d;
      act_q   <= asgn_d ? 8'(owner_d) : LOC_NONE;
    end
  end

  assign assigned   = asgn_q;
  assign granted    = grant_q;
  assign seized     = seize_q;
  assign owner      = owner_q;
  assign active_loc = act_q;

  // R2
  claim_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wr_data == CMD_CLAIM) |=> (asgn_q && grant_q && !seize_q));

  // R3
  release_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wr_data == CMD_RELEASE) |=> (!asgn_q && !grant_q));

  // R4
  other_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wr_data != CMD_CLAIM && wr_data != CMD_RELEASE)
    |=> ($stable(asgn_q) && $stable(grant_q) && $stable(owner_q)));
endmodule

// File: rtl/lo_rd_mux.sv
module lo_rd_mux
  import lo_pkg::*;
#(
  parameter int unsigned LOC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  reg_sel_e         sel,
  input  logic [1:0]       byte_off,
  input  logic             est_flag,
  input  logic             assigned,
  input  logic             granted,
  input  logic             seized,
  input  logic [LOC_W-1:0] owner,
  output logic [31:0]      rd_data,
  output logic             rd_valid
);
  logic [31:0] state_w, sts_w, word;
  logic [31:0] rd_q;
  logic        vld_q;

  always_comb begin
    state_w = '0;
    state_w[ST_VALID_BIT] = 1'b1;
    state_w[ST_ASGN_BIT]  = assigned;
    state_w[ST_OWN_LSB +: ST_OWN_W] = ST_OWN_W'(owner);
    state_w[ST_EST_BIT]   = ~est_flag;
    sts_w = '0;
    sts_w[SS_GRANT_BIT] = granted;
    sts_w[SS_SEIZE_BIT] = seized;
    unique case (sel)
      SEL_STATE: word = state_w;
      SEL_STS:   word = sts_w;
      default:   word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_en;
      if (rd_en) rd_q <= word >> {byte_off, 3'b000};
    end
  end

  assign rd_data  = rd_q;
  assign rd_valid = vld_q;

  // R8
  rd_valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R8
  rd_valid_drops_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
endmodule

// File: rtl/lo_ownership_ctrl.sv
module lo_ownership_ctrl
  import lo_pkg::*;
#(
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned NUM_LOC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       wr_data,
  input  logic              est_flag,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic [7:0]        active_loc
);
  localparam int unsigned LOC_W = ADDR_W - OFF_W;

  reg_sel_e         sel;
  logic [LOC_W-1:0] loc;
  logic [1:0]       byte_off;
  logic             ctrl_wr;
  logic             assigned, granted, seized;
  logic [LOC_W-1:0] owner;

  lo_addr_dec #(.ADDR_W(ADDR_W), .NUM_LOC(NUM_LOC)) dec_i (
    .addr(addr), .wr_en(wr_en), .acc_size(acc_size),
    .sel(sel), .loc(loc), .byte_off(byte_off), .ctrl_wr(ctrl_wr)
  );

  lo_own_regs #(.LOC_W(LOC_W)) regs_i (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .wr_data(wr_data), .wr_loc(loc),
    .assigned(assigned), .granted(granted), .seized(seized), .owner(owner),
    .active_loc(active_loc)
  );

  lo_rd_mux #(.LOC_W(LOC_W)) rdm_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .byte_off(byte_off),
    .est_flag(est_flag), .assigned(assigned), .granted(granted),
    .seized(seized), .owner(owner), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R9
  none_code_chk: assert property (@(posedge clk) disable iff (rst)
    !assigned |-> (active_loc == LOC_NONE));

  // R9
  owner_shown_chk: assert property (@(posedge clk) disable iff (rst)
    assigned |-> (active_loc == 8'(owner)));

  // R5
  narrow_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (acc_size != SZ_WORD || addr[1:0] != 2'b00))
    |=> ($stable(assigned) && $stable(granted)));

  // R6
  foreign_loc_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ({{(32-LOC_W){1'b0}}, addr[ADDR_W-1:OFF_W]} >= NUM_LOC[31:0]))
    |=> ($stable(assigned) && $stable(granted)));
endmodule

// File: tb/lo_ownership_ctrl_tb_top.sv
module lo_ownership_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0] acc_size = 2'd0;
  logic [31:0] wr_data = '0;
  logic est_flag = 1'b1;
  logic [31:0] rd_data;
  logic rd_valid;
  logic [7:0] active_loc;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model
  bit m_asgn = 1'b0, m_grant = 1'b0;
  logic [2:0] m_owner = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lo_ownership_ctrl #(.ADDR_W(ADDR_W), .NUM_LOC(1)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .acc_size(acc_size), .wr_data(wr_data), .est_flag(est_flag),
    .rd_data(rd_data), .rd_valid(rd_valid), .active_loc(active_loc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(logic [11:0] off, bit est);
    logic [31:0] w = '0;
    case ({off[11:2], 2'b00})
      12'h000: w = {24'h0, 1'b1, 2'b00, m_owner, m_asgn, ~est};
      12'h00C: w = {30'h0, 1'b0, m_grant};
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [7:0] exp_active();
    return m_asgn ? {5'b0, m_owner} : 8'hFF;
  endfunction

  task automatic do_write(logic [ADDR_W-1:0] a, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; acc_size = sz; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    if (sz == 2'd2 && a[1:0] == 2'b00 && a[11:0] == 12'h008 && a[14:12] == 3'd0) begin
      if (d == 32'h1) begin m_asgn = 1'b1; m_grant = 1'b1; m_owner = a[14:12]; end
      else if (d == 32'h2) begin m_asgn = 1'b0; m_grant = 1'b0; end
    end
    // R9 owner or none code shown on the edge that applied the write
    check("R9", {24'h0, active_loc}, {24'h0, exp_active()});
  endtask

  task automatic do_read(string req, logic [ADDR_W-1:0] a, logic [1:0] sz);
    logic [31:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a; acc_size = sz;
    e = exp_word(a[11:0], est_flag) >> (8 * a[1:0]);
    @(posedge clk);
    @(negedge clk);
    check(req, rd_data, e);
    // R8 valid one cycle after the strobe
    check("R8", {31'h0, rd_valid}, 32'h1);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    check("R1", {24'h0, active_loc}, 32'hFF);
    do_read("R1", 15'h0000, 2'd2);
    do_read("R1", 15'h000C, 2'd2);
    est_flag = 1'b0;
    // R7 inverse flag merged
    do_read("R7", 15'h0000, 2'd2);
    // R2 claim
    do_write(15'h0008, 2'd2, 32'h1);
    do_read("R2", 15'h0000, 2'd2);
    do_read("R2", 15'h000C, 2'd2);
    // R8 byte offsets and control/unmapped read as zero
    do_read("R8", 15'h0001, 2'd0);
    do_read("R8", 15'h0002, 2'd1);
    do_read("R8", 15'h0008, 2'd2);
    do_read("R8", 15'h0040, 2'd2);
    // R5 narrow and misaligned release dropped
    do_write(15'h0008, 2'd0, 32'h2);
    do_write(15'h0008, 2'd1, 32'h2);
    do_write(15'h0009, 2'd2, 32'h2);
    do_read("R5", 15'h0000, 2'd2);
    // R6 release from locality 1 dropped
    do_write(15'h1008, 2'd2, 32'h2);
    do_read("R6", 15'h000C, 2'd2);
    // R4 seize, establishment reset, zero, multi-bit ignored
    do_write(15'h0008, 2'd2, 32'h4);
    do_write(15'h0008, 2'd2, 32'h8);
    do_write(15'h0008, 2'd2, 32'h0);
    do_write(15'h0008, 2'd2, 32'h3);
    do_read("R4", 15'h0000, 2'd2);
    do_read("R4", 15'h000C, 2'd2);
    // R3 release
    do_write(15'h0008, 2'd2, 32'h2);
    do_read("R3", 15'h0000, 2'd2);
    do_read("R3", 15'h000C, 2'd2);
    // R6 claim from locality 2 dropped
    do_write(15'h2008, 2'd2, 32'h1);
    do_read("R6", 15'h0000, 2'd2);

    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      logic [1:0] sz;
      logic [31:0] d;
      logic [11:0] offs [5];
      logic [31:0] vals [7];
      offs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010};
      vals = '{32'h1, 32'h2, 32'h4, 32'h8, 32'h0, 32'h3, $urandom};
      a  = {3'($urandom_range(0, 2)), offs[$urandom_range(0, 4)]};
      if ($urandom_range(0, 3) == 0) a[1:0] = 2'($urandom);
      sz = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 1)) : 2'd2;
      d  = vals[$urandom_range(0, 6)];
      est_flag = 1'($urandom);
      if ($urandom_range(0, 1) == 0) do_write(a, sz, d);
      else do_read("R8", a, sz);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule